// File: doc/BRIEF.md
# Multiprocessor UART with address filtering

This block is a full-duplex asynchronous serial port controlled through a four-entry, 8-bit register window. Writing the data address starts a transmission. Reading the same address returns the last accepted received byte, which sits in a separate register. The transmitter and receiver run independently. The receiver keeps a finished byte in its buffer while the next frame is already shifting in.

A control/status register carries the following:
- the frame-length and mode bits;
- the ninth bit to send and the ninth bit received;
- the transmit-done and receive-done flags;
- a sticky framing-error bit.

Both done flags are ORed onto a single interrupt output. The bit timing comes from an external enable pulse at sixteen times the bit rate. That pulse may come from a shared baud generator or from a timer.

In 9-bit multiprocessor mode the receiver filters frames in hardware. Only address frames (ninth bit 1) that hit the port's own masked address, or the broadcast pattern, raise the receive-done flag. All other frames leave the buffer and the flags untouched.

The data path has no ready signal, and back-pressure works by flags:
- **Transmit side:** a write to the data address is taken only while the transmitter is idle. Software waits for the transmit-done flag before it writes again.
- **Receive side:** a byte finished while receive-done is still set is dropped.

Top module: `uart_mp`

## Requirements
- R1: After reset the control (address 0), given-address (address 2) and mask (address 3) registers read 0x00, `txd` is 1 and `irq` is 0.
- R2: When the transmitter is idle, a write to address 1 sends a frame on `txd`. The frame is a low start bit, then the 8 data bits LSB first, then control bit 3 as a ninth bit only when control bit 6 is 1, then a high stop bit. Each bit lasts 16 `baud_tick` pulses. When the stop bit ends, control bit 1 (transmit done) is set.
- R3: A write to address 1 while a frame is being sent is ignored, and the frame in progress continues unchanged.
- R4: With control bit 4 (receive enable) set, a received frame stores its byte, which reads back at address 1, and sets control bit 0 (receive done). Control bit 2 takes the ninth bit in 9-bit mode and the stop bit in 8-bit mode.
- R5: Each bit value is the majority of three samples taken at ticks 7, 8 and 9 of the bit, so a glitch one tick wide does not change the received byte.
- R6: A start edge whose majority vote at mid-bit reads high is a false start. No byte is stored and no flag changes.
- R7: A completed frame whose stop bit votes low sets control bit 7 (framing error), and the byte is still stored. Bit 7 stays set until software writes it to 0.
- R8: A frame that completes while control bit 0 is set is discarded, and the buffered byte is kept.
- R9: When control bits 5 and 6 are both set, a frame sets receive done only if its ninth bit is 1 and its byte matches the filter. The byte matches if it is equal to the given address on the bits where the mask is 1, or if it has a 1 at every bit where (given OR mask) is 1. Any other frame leaves the buffer and control unchanged.
- R10: A transmission and a reception that overlap in time both complete correctly.
- R11: `irq` equals control bit 0 OR control bit 1.
- R12: With control bit 4 clear, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Enable pulse at 16x the bit rate |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 given address, 3 mask |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Transmit-done OR receive-done |

## Verification
The transmit line is compared on every cycle against a behavioural frame model. This covers several data values in 8-bit and 9-bit frames, and a write made in the middle of a frame, which separates an ignored write from a restarted frame.

Received frames cover the following cases, each targeting a different fault:
- **Clean frames:** basic reception.
- **A one-tick glitch:** separates a majority vote from a single sample.
- **A short low pulse:** tests false-start rejection.
- **A low stop bit:** tests the framing error and its stickiness.
- **A frame arriving over a full buffer:** tests overrun handling.
- **Frames with receive disabled:** tests the enable.

In multiprocessor mode a data frame, a masked hit, a miss and a broadcast-only hit are sent. Together they tell the masked compare, the broadcast compare and the ninth-bit gate apart. One overlapping transmit and receive pair checks full-duplex operation.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_DATA  = 2'd1,
    A_GIVEN = 2'd2,
    A_MASK  = 2'd3
  } reg_addr_e;

  // control/status bit positions
  localparam int C_RXDONE = 0;
  localparam int C_TXDONE = 1;
  localparam int C_RX9    = 2;
  localparam int C_TX9    = 3;
  localparam int C_RXEN   = 4;
  localparam int C_MPEN   = 5;
  localparam int C_NINE   = 6;
  localparam int C_FERR   = 7;
endpackage

// File: rtl/uart_mp_tx.sv
module uart_mp_tx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  logic          bit9,
  input  logic          nine,
  output logic          busy,
  output logic          txd,
  output logic          done
);
  localparam int SW = $clog2(OSR);
  localparam int BW = $clog2(DW + 3);

  logic [SW-1:0] sub;
  logic [BW-1:0] bcnt;
  logic [BW-1:0] last;
  logic [DW+1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      done <= 1'b0;
      sub  <= '0;
      bcnt <= '0;
      last <= '0;
      sh   <= '1;
    end else begin
      done <= 1'b0;
      if (!busy && load) begin
        busy <= 1'b1;
        txd  <= 1'b0;
        sub  <= '0;
        bcnt <= '0;
        sh   <= {1'b1, (nine ? bit9 : 1'b1), data};
        last <= nine ? BW'(DW + 2) : BW'(DW + 1);
      end else if (busy && tick) begin
        if (sub == SW'(OSR - 1)) begin
          sub <= '0;
          if (bcnt == last) begin
            busy <= 1'b0;
            txd  <= 1'b1;
            done <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
            txd  <= sh[0];
            sh   <= {1'b1, sh[DW+1:1]};
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          ferr_o
);
  localparam int SW  = $clog2(OSR);
  localparam int BW  = $clog2(DW + 3);
  localparam int MID = OSR / 2;

  logic [1:0]    sync;
  logic          rxs;
  logic          active;
  logic          nine_q;
  logic [SW-1:0] sub;
  logic [BW-1:0] bcnt;
  logic [BW-1:0] last;
  logic [1:0]    samp;
  logic [DW-1:0] dsh;
  logic          ninth;
  logic          vote;

  assign rxs  = sync[1];
  assign vote = (samp[1] & samp[0]) | (samp[1] & rxs) | (samp[0] & rxs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      active <= 1'b0;
      nine_q <= 1'b0;
      sub    <= '0;
      bcnt   <= '0;
      last   <= '0;
      samp   <= 2'b11;
      dsh    <= '0;
      ninth  <= 1'b0;
      done   <= 1'b0;
      data_o <= '0;
      bit9_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      done <= 1'b0;
      sync <= {sync[0], rxd};
      if (!active) begin
        if (tick && en && !rxs) begin
          active <= 1'b1;
          sub    <= '0;
          bcnt   <= '0;
          nine_q <= nine;
          last   <= nine ? BW'(DW + 2) : BW'(DW + 1);
        end
      end else if (tick) begin
        if (sub == SW'(OSR - 1)) begin
          sub  <= '0;
          bcnt <= bcnt + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
        if (sub == SW'(MID - 1) || sub == SW'(MID))
          samp <= {samp[0], rxs};
        if (sub == SW'(MID + 1)) begin
          if (bcnt == '0) begin
            if (vote) active <= 1'b0;          // false start
          end else if (bcnt == last) begin
            active <= 1'b0;
            done   <= 1'b1;
            ferr_o <= !vote;
            bit9_o <= nine_q ? ninth : vote;
            data_o <= dsh;
          end else if (bcnt <= BW'(DW)) begin
            dsh <= {vote, dsh[DW-1:1]};
          end else begin
            ninth <= vote;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_mp_match.sv
module uart_mp_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx,
  input  logic [DW-1:0] given,
  input  logic [DW-1:0] mask,
  output logic          hit
);
  logic [DW-1:0] bcast;
  logic          own_hit;
  logic          bcast_hit;

  assign bcast     = given | mask;
  assign own_hit   = ((rx & mask) == (given & mask));
  assign bcast_hit = ((rx & bcast) == bcast);
  assign hit       = own_hit | bcast_hit;
endmodule

// File: rtl/uart_mp.sv
module uart_mp
  import uart_mp_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  logic [DATA_W-1:0] ctrl;
  logic [DATA_W-1:0] given_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] rx_buf;

  logic wr_ctrl, wr_data, wr_given, wr_mask;
  logic tx_busy, tx_done;
  logic rx_done, rx_b9, rx_ferr;
  logic [DATA_W-1:0] rx_data;
  logic hit, mp_on, accept;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_data  = reg_wr && (reg_addr == A_DATA);
  assign wr_given = reg_wr && (reg_addr == A_GIVEN);
  assign wr_mask  = reg_wr && (reg_addr == A_MASK);

  uart_mp_tx #(.DW(DATA_W), .OSR(OSR)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (baud_tick),
    .load (wr_data),
    .data (reg_wdata),
    .bit9 (ctrl[C_TX9]),
    .nine (ctrl[C_NINE]),
    .busy (tx_busy),
    .txd  (txd),
    .done (tx_done)
  );

  uart_mp_rx #(.DW(DATA_W), .OSR(OSR)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (baud_tick),
    .en    (ctrl[C_RXEN]),
    .nine  (ctrl[C_NINE]),
    .rxd   (rxd),
    .done  (rx_done),
    .data_o(rx_data),
    .bit9_o(rx_b9),
    .ferr_o(rx_ferr)
  );

  uart_mp_match #(.DW(DATA_W)) u_match (
    .rx   (rx_data),
    .given(given_q),
    .mask (mask_q),
    .hit  (hit)
  );

  assign mp_on  = ctrl[C_MPEN] & ctrl[C_NINE];
  assign accept = rx_done && !ctrl[C_RXDONE] && (!mp_on || (rx_b9 && hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      given_q <= '0;
      mask_q  <= '0;
      rx_buf  <= '0;
    end else begin
      if (wr_ctrl)  ctrl    <= reg_wdata;
      if (wr_given) given_q <= reg_wdata;
      if (wr_mask)  mask_q  <= reg_wdata;
      if (accept) begin
        ctrl[C_RXDONE] <= 1'b1;
        ctrl[C_RX9]    <= rx_b9;
        rx_buf         <= rx_data;
      end
      if (rx_done && rx_ferr) ctrl[C_FERR]   <= 1'b1;
      if (tx_done)            ctrl[C_TXDONE] <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl;
      A_DATA:  reg_rdata = rx_buf;
      A_GIVEN: reg_rdata = given_q;
      default: reg_rdata = mask_q;
    endcase
  end

  assign irq = ctrl[C_RXDONE] | ctrl[C_TXDONE];
endmodule

// File: rtl/uart_mp_chk.sv
module uart_mp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       txd,
  input logic [7:0] ctrl,
  input logic       tx_busy,
  input logic [7:0] rx_buf
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 2'd0);

  assert_txd_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_txd_holds_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !baud_tick) |=> $stable(txd));

  assert_txdone_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl[1]) && !$past(ctrl_wr)) |-> !tx_busy);

  assert_ferr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && !ctrl_wr) |=> ctrl[7]);

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] |=> $stable(rx_buf));

  assert_mp_address_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl[0]) && ctrl[5] && ctrl[6] && !$past(ctrl_wr)) |-> ctrl[2]);
endmodule

bind uart_mp uart_mp_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .baud_tick(baud_tick),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .txd      (txd),
  .ctrl     (ctrl),
  .tx_busy  (tx_busy),
  .rx_buf   (rx_buf)
);

// File: tb/sim_uart_mp.sv
module sim_uart_mp;
  localparam int DIV  = 4;
  localparam int OSR  = 16;
  localparam int BITC = OSR * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_mp #(.OSR(OSR)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  // baud enable: one pulse every DIV clocks
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt == DIV - 1) ? 0 : tcnt + 1;
    baud_tick = (tcnt == DIV - 1);
  end

  // behavioural transmit-line model
  logic        m_busy = 1'b0, m_txd = 1'b1, m_nine = 1'b0, m_tx9 = 1'b0;
  logic [10:0] m_frame = '1;
  int          m_sub = 0, m_idx = 0, m_nbits = 10;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_txd = 1'b1; m_nine = 1'b0; m_tx9 = 1'b0;
    end else begin
      if (m_busy && baud_tick) begin
        if (m_sub == OSR - 1) begin
          m_sub = 0;
          m_idx = m_idx + 1;
          if (m_idx == m_nbits) begin
            m_busy = 1'b0; m_txd = 1'b1;
          end else begin
            m_txd = m_frame[m_idx];
          end
        end else begin
          m_sub = m_sub + 1;
        end
      end else if (!m_busy && reg_wr && reg_addr == 2'd1) begin
        m_busy  = 1'b1;
        m_frame = m_nine ? {1'b1, m_tx9, reg_wdata, 1'b0} : {2'b11, reg_wdata, 1'b0};
        m_nbits = m_nine ? 11 : 10;
        m_idx = 0; m_sub = 0; m_txd = 1'b0;
      end
      if (reg_wr && reg_addr == 2'd0) begin
        m_nine = reg_wdata[6];
        m_tx9  = reg_wdata[3];
      end
    end
  end

  // per-cycle comparison of the serial output (R2, R3, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (txd !== m_txd) begin
        errors++;
        $display("FAIL R2/R3/R10 txd actual %b expected %b at %0t", txd, m_txd, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic b9, input logic nine,
                         input logic stop, input logic glitch);
    @(negedge clk);
    rxd = 1'b0; hold(BITC);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      if (glitch && i == 0) begin
        hold(8 * DIV); rxd = ~d[0]; hold(DIV); rxd = d[0]; hold(7 * DIV);
      end else begin
        hold(BITC);
      end
    end
    if (nine) begin rxd = b9; hold(BITC); end
    rxd = stop;
    if (stop) hold(BITC);
    else begin hold(12 * DIV); rxd = 1'b1; hold(4 * DIV); end
    rxd = 1'b1; hold(2 * BITC);
  endtask

  task automatic expect_rx(input string req, input logic [7:0] ectrl, input logic [7:0] edata);
    logic [7:0] v;
    rd(2'd0, v); chk({req, " control"}, v, ectrl);
    rd(2'd1, v); chk({req, " data"}, v, edata);
  endtask

  initial begin
    logic [7:0] v;
    hold(4);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); chk("R1 control", v, 8'h00);
    rd(2'd2, v); chk("R1 given", v, 8'h00);
    rd(2'd3, v); chk("R1 mask", v, 8'h00);
    chk("R1 txd", {7'd0, txd}, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 / R3: 8-bit transmit, mid-frame write ignored
    wr(2'd1, 8'hA5);
    hold(3 * BITC);
    wr(2'd1, 8'h3C);
    hold(8 * BITC);
    rd(2'd0, v); chk("R2 tx done flag", v, 8'h02);
    chk("R11 irq on tx done", {7'd0, irq}, 8'h01);
    hold(2 * BITC);
    chk("R3 no second frame", {7'd0, txd}, 8'h01);

    // R4: 8-bit receive, ninth status takes stop bit
    wr(2'd0, 8'h10);
    chk("R11 irq cleared", {7'd0, irq}, 8'h00);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_rx("R4", 8'h15, 8'h5A);

    // R5: glitch on one sample
    wr(2'd0, 8'h10);
    send_rx(8'hC3, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_rx("R5", 8'h15, 8'hC3);

    // R6: false start
    wr(2'd0, 8'h10);
    @(negedge clk); rxd = 1'b0; hold(4 * DIV); rxd = 1'b1;
    hold(12 * BITC);
    expect_rx("R6", 8'h10, 8'hC3);

    // R7: framing error, byte kept, flag sticky
    send_rx(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_rx("R7 bad stop", 8'h91, 8'h77);
    wr(2'd0, 8'h90);
    send_rx(8'h21, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_rx("R7 sticky", 8'h95, 8'h21);

    // R8: overrun discards new byte
    send_rx(8'h11, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_rx("R8", 8'h95, 8'h21);
    wr(2'd0, 8'h10);
    rd(2'd0, v); chk("R7 software clear", v, 8'h10);

    // R12: receiver disabled
    wr(2'd0, 8'h00);
    send_rx(8'h44, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_rx("R12", 8'h00, 8'h21);

    // R4 / R2 / R10: 9-bit frames, overlapping transmit and receive
    wr(2'd0, 8'h58);
    fork
      wr(2'd1, 8'h81);
      send_rx(8'h3E, 1'b0, 1'b1, 1'b1, 1'b0);
    join
    hold(2 * BITC);
    expect_rx("R4 nine-bit", 8'h5B, 8'h3E);

    // R9: address filtering
    wr(2'd2, 8'h4A);
    wr(2'd3, 8'hF0);
    rd(2'd2, v); chk("R9 given readback", v, 8'h4A);
    rd(2'd3, v); chk("R9 mask readback", v, 8'hF0);
    wr(2'd0, 8'h70);
    send_rx(8'h4A, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_rx("R9 data frame", 8'h70, 8'h3E);
    send_rx(8'h43, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_rx("R9 masked hit", 8'h75, 8'h43);
    wr(2'd0, 8'h70);
    send_rx(8'h52, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_rx("R9 miss", 8'h70, 8'h43);
    send_rx(8'hFB, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_rx("R9 broadcast", 8'h75, 8'hFB);

    // R10: full duplex in 8-bit mode
    wr(2'd0, 8'h10);
    fork
      wr(2'd1, 8'h96);
      send_rx(8'h2D, 1'b0, 1'b0, 1'b1, 1'b0);
    join
    hold(2 * BITC);
    expect_rx("R10", 8'h17, 8'h2D);
    chk("R11 irq both", {7'd0, irq}, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule